// File: doc/BRIEF.md
# Half-overlap frame recombiner

This block rebuilds one continuous sample stream from time-domain frames that come back from an inverse transform. Frames are 64 signed 16-bit samples long. Each frame is tagged as part of one of two streams that are offset by half a frame. The block keeps one 64-entry frame buffer for each stream, and the tag of a frame picks the buffer it goes into. When a frame has arrived in full, the block pairs the new frame's first half with the half-frame still held in the other buffer, which is the second half of the previous frame. It adds the two halves sample by sample with saturation and writes the 32 sums into an output FIFO.

Frames arrive over a valid/ready stream that carries a tag bit and an end-of-frame flag. A frame of the wrong length is dropped and sets a sticky error flag. If the output FIFO lacks room for a full half-frame burst, the block waits and holds its input ready low until room appears. Output samples leave through a valid/ready stream in the order they were produced.

Top module: `hor_recombiner`

## Requirements
- R1: A frame is written into the buffer selected by the tag on its first sample (0 = stream A, 1 = stream B). Tag values on the later samples of the same frame are ignored.
- R2: Each frame of correct length yields exactly 32 output samples, and none of them appears before the frame's last sample has been accepted. A frame of wrong length yields no output.
- R3: Output sample i (i = 0..31) of a frame equals new[i] + old[32+i]. Here new is the frame just completed and old is the half-frame left in the other buffer by the previous combine.
- R4: If the other buffer holds no leftover half, the partner samples are zero. This covers the first frame after reset, a frame that follows a frame of the same tag, and a frame that follows a dropped frame in the other buffer. In that case output i equals new[i].
- R5: The sum is saturated to the signed 16-bit range: above 32767 gives 32767, below -32768 gives -32768.
- R6: When the output FIFO lacks room for 32 samples, the combine waits and in_ready stays low. No sample is lost or overwritten, and the output resumes in order once the FIFO has been drained.
- R7: A frame is correct only when in_last is set on its 64th sample. A frame ends at in_last or at its 64th sample, whichever comes first. A frame of any other length sets err_len, which stays set until reset, and leaves its target buffer empty.
- R8: After reset, out_valid is 0, in_ready is 1 and err_len is 0.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_tag | input | 1 | Stream tag, sampled on a frame's first sample (0 = A, 1 = B) |
| in_last | input | 1 | Marks the last sample of a frame |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | 16 | Reconstructed sample, two's complement |
| err_len | output | 1 | Sticky flag for a frame of wrong length |

## Verification
Strictly alternating tags with random data check the pairing of a new first half with the older second half. Repeated tags, a frame right after reset and frames that follow a dropped frame check that the partner falls back to zero when no leftover half exists. Tags toggled in the middle of a frame show that routing is decided only by the first sample. Frames filled with large values of one sign check clamping at both ends, and a consumer that stops long enough to fill the FIFO checks that the stall loses nothing. Short frames and a frame of 64 samples without an end flag check the error path.

// File: rtl/hor_pkg.sv
package hor_pkg;
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'd0,
    LVL_HALF  = 2'd1,
    LVL_FULL  = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } state_e;
endpackage

// File: rtl/hor_frame_buf.sv
module hor_frame_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // one write port and one registered read port, as a block RAM provides
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hor_sat_add.sv
module hor_sat_add #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         zero_b,
  output logic         out_valid,
  output logic [W-1:0] sum
);
  logic [W-1:0] b_sel;
  logic [W:0]   wide;
  logic [W-1:0] clamped;

  always_comb begin
    b_sel = zero_b ? '0 : b;
    wide  = {a[W-1], a} + {b_sel[W-1], b_sel};
    if (wide[W] != wide[W-1])
      clamped = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      clamped = wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    sum <= clamped;
  end
endmodule

// File: rtl/hor_out_fifo.sv
module hor_out_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int PAW  = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic [CW-1:0] count,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  logic [W-1:0]   mem [DEPTH];
  logic [PAW-1:0] wr_ptr, rd_ptr;
  logic           pop;

  assign pop = (count != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
    if (pop)  out_data    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PAW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PAW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (pop)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hor_recombiner.sv
module hor_recombiner
  import hor_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAME_LEN  = 64,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tag,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err_len
);
  localparam int HALF = FRAME_LEN / 2;
  localparam int AW   = $clog2(FRAME_LEN);
  localparam int HW   = $clog2(HALF);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);

  state_e          state;
  level_e          lvl [2];
  logic [AW-1:0]   wr_idx;
  logic [HW-1:0]   rd_idx;
  logic            cur_tag, newer;
  logic            tag_w, accept, frame_end, frame_ok;
  logic            issue, rd_vld_q, zero_q;
  logic [AW-1:0]   raddr [2];
  logic [DATA_W-1:0] rdata [2];
  logic            sat_vld;
  logic [DATA_W-1:0] sat_sum;
  logic [CW-1:0]   fifo_cnt;
  logic [CW-1:0]   fifo_free;

  assign in_ready  = (state == ST_FILL);
  assign accept    = in_valid && in_ready;
  assign tag_w     = (wr_idx == '0) ? in_tag : cur_tag;
  assign frame_end = accept && (in_last || wr_idx == AW'(FRAME_LEN - 1));
  assign frame_ok  = in_last && (wr_idx == AW'(FRAME_LEN - 1));
  assign issue     = (state == ST_RUN);
  assign fifo_free = CW'(FIFO_DEPTH) - fifo_cnt;

  // two frame stores, one per stream
  for (genvar g = 0; g < 2; g++) begin : g_buf
    assign raddr[g] = (newer == 1'(g)) ? AW'(rd_idx) : AW'(HALF) + AW'(rd_idx);
    hor_frame_buf #(.W(DATA_W), .DEPTH(FRAME_LEN)) buf_i (
      .clk   (clk),
      .we    (accept && (tag_w == 1'(g))),
      .waddr (wr_idx),
      .wdata (in_data),
      .raddr (raddr[g]),
      .rdata (rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FILL;
      lvl[0]   <= LVL_EMPTY;
      lvl[1]   <= LVL_EMPTY;
      wr_idx   <= '0;
      rd_idx   <= '0;
      cur_tag  <= 1'b0;
      newer    <= 1'b0;
      err_len  <= 1'b0;
      rd_vld_q <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      rd_vld_q <= issue;
      zero_q   <= (lvl[~newer] != LVL_HALF);
      case (state)
        ST_FILL: begin
          if (accept) begin
            if (wr_idx == '0) begin
              cur_tag      <= in_tag;
              lvl[in_tag]  <= LVL_EMPTY;
            end
            if (frame_end) begin
              wr_idx <= '0;
              if (frame_ok) begin
                lvl[tag_w] <= LVL_FULL;
                newer      <= tag_w;
                state      <= ST_WAIT;
              end else begin
                lvl[tag_w] <= LVL_EMPTY;
                err_len    <= 1'b1;
              end
            end else begin
              wr_idx <= wr_idx + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (fifo_free >= CW'(HALF)) begin
            rd_idx <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == HW'(HALF - 1)) begin
            lvl[newer]  <= LVL_HALF;
            lvl[~newer] <= LVL_EMPTY;
            state       <= ST_FILL;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  hor_sat_add #(.W(DATA_W)) add_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_vld_q),
    .a         (rdata[newer]),
    .b         (rdata[~newer]),
    .zero_b    (zero_q),
    .out_valid (sat_vld),
    .sum       (sat_sum)
  );

  hor_out_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push      (sat_vld),
    .push_data (sat_sum),
    .count     (fifo_cnt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/hor_recombiner_chk.sv
module hor_recombiner_chk #(
  parameter int DATA_W     = 16,
  parameter int FRAME_LEN  = 64,
  parameter int FIFO_DEPTH = 64,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err_len,
  input logic              fifo_push,
  input logic [CW-1:0]     fifo_cnt
);
  localparam int HALF = FRAME_LEN / 2;
  int unsigned push_run;

  always_ff @(posedge clk) begin
    if (rst) push_run <= 0;
    else if (in_valid && in_ready && in_last) push_run <= 0;
    else if (fifo_push) push_run <= push_run + 1;
  end

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready && !err_len));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_len |=> err_len);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (fifo_cnt != CW'(FIFO_DEPTH)));

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (push_run < HALF));
endmodule

bind hor_recombiner hor_recombiner_chk #(
  .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err_len   (err_len),
  .fifo_push (sat_vld),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/hor_recombiner_tb.sv
module hor_recombiner_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_tag, in_last;
  logic signed [15:0] in_data;
  logic out_valid, out_ready;
  logic signed [15:0] out_data;
  logic err_len;

  int total = 0;
  int bad = 0;
  int rx_cnt = 0;
  int cmode = 0;
  string cur_req = "R3";
  int expq [$];
  int frm [64];
  int mbuf [2][64];
  bit mlvl [2];

  always #5 clk = ~clk;

  hor_recombiner dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_len(err_len)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // consumer: decides out_ready at the falling edge, records the transfer at the next rising edge
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (cmode)
        0: out_ready = 1'($urandom % 2);
        1: out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
      if (out_valid && out_ready) begin
        rx_cnt++;
        if (expq.size() == 0) check(1'b0, "R2", int'(out_data), 0);
        else begin
          int e;
          e = expq.pop_front();
          check(int'(out_data) == e, cur_req, int'(out_data), e);
        end
      end
    end
  end

  task automatic send_frame(bit tag, int len, bit with_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_tag   = (i == 0) ? tag : 1'($urandom);
      in_data  = 16'(frm[i]);
      in_last  = with_last && (i == len - 1);
      while (!in_ready) @(negedge clk);
      if (i == 0) mlvl[tag] = 1'b0;
    end
    if (with_last && len == 64) begin
      for (int i = 0; i < 32; i++)
        expq.push_back(sat16(frm[i] + (mlvl[~tag] ? mbuf[~tag][32 + i] : 0)));
      mlvl[~tag] = 1'b0;
      for (int i = 0; i < 64; i++) mbuf[tag][i] = frm[i];
      mlvl[tag] = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 64; i++) begin
      case ($urandom % 8)
        0: frm[i] = 32767 - int'($urandom % 200);
        1: frm[i] = -32768 + int'($urandom % 200);
        default: frm[i] = int'($signed(16'($urandom)));
      endcase
    end
  endtask

  task automatic fill_halves(int first, int second);
    for (int i = 0; i < 64; i++) frm[i] = (i < 32) ? first : second;
  endtask

  task automatic flush(string req, int exp_rx);
    int n = 0;
    while ((expq.size() != 0 || out_valid) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (10) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
    check(rx_cnt == exp_rx, req, rx_cnt, exp_rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tag;
    int exp_rx;
    int hi;
    void'($urandom(32'h5eed_1234));
    mlvl[0] = 1'b0;
    mlvl[1] = 1'b0;
    rst = 1'b1; in_valid = 1'b0; in_tag = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", int'(in_ready), 1);
    check(err_len == 1'b0, "R8", int'(err_len), 0);

    // R4: first frame after reset pairs with zeros
    cur_req = "R4";
    fill_rand();
    send_frame(1'b0, 64, 1'b1);
    exp_rx = 32;
    flush("R2", exp_rx);

    // R3: alternating tags
    cur_req = "R3";
    tag = 1;
    for (int k = 0; k < 6; k++) begin
      fill_rand();
      send_frame(1'(tag), 64, 1'b1);
      tag = 1 - tag;
    end
    exp_rx += 6 * 32;
    flush("R3", exp_rx);

    // R1: repeated tag gets a zero partner; mid-frame tag toggles ignored
    cur_req = "R1";
    fill_rand(); send_frame(1'(1 - tag), 64, 1'b1);
    fill_rand(); send_frame(1'(1 - tag), 64, 1'b1);
    fill_rand(); send_frame(1'(tag), 64, 1'b1);
    exp_rx += 3 * 32;
    flush("R1", exp_rx);

    // R5: saturation at both ends
    cur_req = "R5";
    fill_halves(100, 30000);  send_frame(1'b0, 64, 1'b1);
    fill_halves(30000, -30000); send_frame(1'b1, 64, 1'b1);
    fill_halves(-30000, 5);  send_frame(1'b0, 64, 1'b1);
    fill_halves(32767, 0);   send_frame(1'b1, 64, 1'b1);
    exp_rx += 4 * 32;
    flush("R5", exp_rx);

    // R7: wrong lengths raise the flag, give no output and empty the buffer
    cur_req = "R7";
    fill_rand(); send_frame(1'b0, 64, 1'b1);
    fill_rand(); send_frame(1'b1, 10, 1'b1);
    repeat (5) @(negedge clk);
    check(err_len == 1'b1, "R7", int'(err_len), 1);
    fill_rand(); send_frame(1'b1, 64, 1'b0);
    fill_rand(); send_frame(1'b0, 1, 1'b1);
    fill_rand(); send_frame(1'b1, 64, 1'b1);
    exp_rx += 2 * 32;
    flush("R7", exp_rx);
    check(err_len == 1'b1, "R7", int'(err_len), 1);

    // R6: stalled consumer fills the FIFO, input is held off, nothing lost
    cur_req = "R6";
    cmode = 1;
    tag = 0;
    for (int k = 0; k < 3; k++) begin
      fill_rand();
      send_frame(1'(tag), 64, 1'b1);
      tag = 1 - tag;
    end
    hi = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (in_ready) hi++;
    end
    check(hi == 0, "R6", hi, 0);
    check(out_valid == 1'b1, "R6", int'(out_valid), 1);
    cmode = 0;
    fill_rand();
    send_frame(1'(tag), 64, 1'b1);
    exp_rx += 4 * 32;
    flush("R6", exp_rx);

    // random mix, mostly alternating tags
    cur_req = "R3";
    cmode = 2;
    for (int k = 0; k < 20; k++) begin
      if ($urandom % 5 != 0) tag = 1 - tag;
      if (k == 10) cmode = 0;
      fill_rand();
      send_frame(1'(tag), 64, 1'b1);
    end
    exp_rx += 20 * 32;
    flush("R3", exp_rx);
    check(err_len == 1'b1, "R7", int'(err_len), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule